// File: doc/BRIEF.md
# Relocatable Write-Once Configuration Register Window

This block is a small I/O-mapped register file for chip configuration. After reset it is dark except for one fixed bootstrap port. Boot firmware writes a 16-bit base address to that port. The first complete write is taken, and the port then stays locked until the next reset. From then on the register file answers in a 64-byte window at the programmed base.

Inside the window the block holds several kinds of storage:
- plain read/write configuration words with their reset values;
- a watchdog status byte whose bits are set by event inputs and cleared by writing 1;
- read-only views of a timer value, two identity bytes and the programmed base;
- two strap values captured while reset is asserted.

Reserved bytes and reserved words are ordinary storage, so they read back whatever was last written to them. The bus is a 32-bit data path with byte addresses and four byte enables. A read returns the whole addressed 32-bit word combinationally while `rd` is high.

Top module: `cfg_window`

## Requirements
- R1: After reset `cfg_locked` is 0 and `cfg_base` is 0000h. While unlocked, a read at any address outside the bootstrap word returns 0. A write there changes no register.
- R2: The bootstrap port sits at byte address 02EAh, which is the upper half (lanes 3:2) of word 02E8h. A write to word 02E8h with `be[3:2]`=11 loads `wdata[31:16]` into `cfg_base` and sets `cfg_locked`.
- R3: Once `cfg_locked` is set, it stays set and `cfg_base` does not change until reset. Further bootstrap writes are ignored.
- R4: When locked, an access hits the window only when `addr[15:6]` equals `cfg_base[15:6]`. Word `addr[5:2]` is selected. Reads outside the window return 0.
- R5: The reset values are:
  - 00h: 00000000h
  - 0Ch: 00000000h
  - byte 12h: 2Fh
  - 18h: E1040005h
  - 30h: 00000000h
  - 34h: 00000001h
  - 38h: 00000000h
- R6: A write changes exactly the bytes whose enable bit is set. Lane n is `wdata[8n+7:8n]`.
- R7: Reserved locations read back the last value written to them. Examples are bytes 05h–07h and word 20h.
- R8: Byte 04h is the watchdog status. A 1 on `wd_evt[i]` sets bit i. Writing 1 to bit i clears it. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: The following locations ignore writes:
  - word 08h returns `tmr_value`;
  - byte 10h returns `strap_mult` as captured in reset;
  - byte 3Ch returns the ID parameter;
  - byte 3Dh returns the revision parameter;
  - bytes 3Eh–3Fh return `cfg_base`.
- R10: Bytes 1Eh–1Fh hold the `strap_ccfc` value captured during reset, and they are writable afterwards.
- R11: While `rd` is low, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| addr | input | 16 | I/O byte address |
| be | input | 4 | Byte enables for the addressed 32-bit word |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| wd_evt | input | 8 | Watchdog status set events |
| tmr_value | input | 32 | Live timer value shown at offset 08h |
| strap_mult | input | 8 | Strap value captured into offset 10h |
| strap_ccfc | input | 16 | Strap value captured into offsets 1Eh–1Fh |
| cfg_base | output | 16 | Programmed window base |
| cfg_locked | output | 1 | Bootstrap port has been written |

## Verification
The properties assume that the bootstrap port lies in the upper half of its word, that `wr` and `rd` are never high together, and that the straps are stable while reset is low. The bench drives one strobe at a time. It uses a 64-byte-aligned base that keeps the window clear of the bootstrap word, and it holds the strap inputs constant for the whole run. Event and clear inputs change only at falling edges, so the set-wins case is created deliberately within a single cycle.

// File: rtl/cfg_window.sv
module cfg_window #(
  parameter logic [15:0] BOOT_PORT = 16'h02EA,
  parameter logic [7:0]  DEV_ID    = 8'hC4,
  parameter logic [7:0]  DEV_REV   = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [3:0]  be,
  input  logic        wr,
  input  logic        rd,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [7:0]  wd_evt,
  input  logic [31:0] tmr_value,
  input  logic [7:0]  strap_mult,
  input  logic [15:0] strap_ccfc,
  output logic [15:0] cfg_base,
  output logic        cfg_locked
);
  localparam int NW = 16;

  function automatic logic [31:0] rst_word(input int i);
    case (i)
      4:       return 32'h002F_0000;
      6:       return 32'hE104_0005;
      13:      return 32'h0000_0001;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] ro_lanes(input int i);
    case (i)
      1, 4:    return 4'b0001;
      2, 15:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  logic [15:0] base_q;
  logic        locked_q;
  logic [7:0]  wd_stat, mult_q;
  logic [NW-1:0][31:0] words;
  logic [31:0] word;
  logic [3:0]  idx;
  logic        win, port_hit;
  logic [1:0]  boot_be;
  logic [15:0] boot_data;
  logic [1:0]  unused_lsb;

  assign unused_lsb = addr[1:0];
  assign idx        = addr[5:2];
  assign win        = locked_q && (addr[15:6] == base_q[15:6]);
  assign port_hit   = (addr[15:2] == BOOT_PORT[15:2]);
  assign boot_be    = BOOT_PORT[1] ? be[3:2] : be[1:0];
  assign boot_data  = BOOT_PORT[1] ? wdata[31:16] : wdata[15:0];
  assign cfg_base   = base_q;
  assign cfg_locked = locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      locked_q <= 1'b0;
    end else if (wr && port_hit && !locked_q && boot_be == 2'b11) begin
      base_q   <= boot_data;
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_stat <= '0;
      mult_q  <= strap_mult;
    end else begin
      wd_stat <= (wd_stat & ~((wr && win && idx == 4'd1 && be[0]) ? wdata[7:0] : 8'h00)) | wd_evt;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam logic [31:0] RV  = rst_word(w);
    localparam logic [3:0]  ROL = ro_lanes(w);
    for (genvar b = 0; b < 4; b++) begin : g_lane
      if (ROL[b]) begin : g_ro
        assign words[w][8*b +: 8] = 8'h00;
      end else begin : g_rw
        logic [7:0] q;
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            if (w == 7 && b >= 2) q <= strap_ccfc[8*(b%2) +: 8];
            else                  q <= RV[8*b +: 8];
          end else if (wr && win && idx == w && be[b]) begin
            q <= wdata[8*b +: 8];
          end
        end
        assign words[w][8*b +: 8] = q;
      end
    end
  end

  always_comb begin
    word = words[idx];
    case (idx)
      4'd1:  word[7:0] = wd_stat;
      4'd2:  word      = tmr_value;
      4'd4:  word[7:0] = mult_q;
      4'd15: word      = {base_q, DEV_REV, DEV_ID};
      default: ;
    endcase
  end

  assign rdata = !rd      ? 32'h0 :
                 win      ? word  :
                 port_hit ? (BOOT_PORT[1] ? {base_q, 16'h0} : {16'h0, base_q}) :
                            32'h0;
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk #(
  parameter logic [15:0] PORT = 16'h02EA
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic [3:0]  be,
  input logic        wr,
  input logic        rd,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic [7:0]  wd_evt,
  input logic [31:0] tmr_value,
  input logic [15:0] cfg_base,
  input logic        cfg_locked,
  input logic [7:0]  wd_stat,
  input logic        win
);
  p_boot_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_locked && wr && addr[15:2] == PORT[15:2] && be[3:2] == 2'b11)
      |=> (cfg_locked && cfg_base == $past(wdata[31:16])));

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> cfg_locked);

  p_base_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> $stable(cfg_base));

  p_prelock_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_locked && rd && addr[15:2] != PORT[15:2]) |-> rdata == 32'h0);

  p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_evt != 8'h0) |=> ((wd_stat & $past(wd_evt)) == $past(wd_evt)));

  p_timer_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && win && addr[5:2] == 4'd2) |-> rdata == tmr_value);
endmodule

bind cfg_window cfg_window_chk #(.PORT(BOOT_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .be(be), .wr(wr), .rd(rd),
  .wdata(wdata), .rdata(rdata), .wd_evt(wd_evt), .tmr_value(tmr_value),
  .cfg_base(cfg_base), .cfg_locked(cfg_locked), .wd_stat(wd_stat), .win(win)
);

// File: tb/cfg_window_tb.sv
`timescale 1ns/1ps
module cfg_window_tb;
  logic        clk = 0, rst_n = 0;
  logic [15:0] addr = 0;
  logic [3:0]  be = 0;
  logic        wr = 0, rd = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0]  wd_evt = 0;
  logic [31:0] tmr_value = 32'hCAFE_F00D;
  logic [7:0]  strap_mult = 8'h0B;
  logic [15:0] strap_ccfc = 16'h1234;
  logic [15:0] cfg_base;
  logic        cfg_locked;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [15:0] B = 16'h9A40;

  always #5 clk = ~clk;

  cfg_window u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [3:0] e, logic [31:0] d);
    @(negedge clk); addr = a; be = e; wdata = d; wr = 1;
    @(negedge clk); wr = 0; be = 0;
  endtask

  task automatic bus_rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    rd = 0;
  endtask

  task automatic t_reset_dark;
    logic [31:0] d;
    chk("R1 locked", {31'h0, cfg_locked}, 0);
    chk("R1 base", {16'h0, cfg_base}, 0);
    bus_wr(B + 16'h30, 4'hF, 32'h5555_5555);
    bus_rd(B + 16'h30, d); chk("R1 prelock read", d, 0);
  endtask

  task automatic t_boot;
    logic [31:0] d;
    bus_wr(16'h02E8, 4'b0100, {B, 16'h0});
    chk("R2 partial ignored", {31'h0, cfg_locked}, 0);
    bus_wr(16'h02E8, 4'b1100, {B, 16'h0});
    chk("R2 locked", {31'h0, cfg_locked}, 1);
    chk("R2 base", {16'h0, cfg_base}, {16'h0, B});
    bus_rd(B + 16'h30, d); chk("R1 prelock write had no effect", d, 0);
  endtask

  task automatic t_relock;
    logic [31:0] d;
    bus_wr(16'h02E8, 4'b1100, 32'h1100_0000);
    chk("R3 base kept", {16'h0, cfg_base}, {16'h0, B});
    bus_rd(B + 16'h3C, d); chk("R3/R9 id word", d, {B, 8'h02, 8'hC4});
  endtask

  task automatic t_decode;
    logic [31:0] d;
    bus_rd(B + 16'h40, d); chk("R4 above window", d, 0);
    bus_rd(16'h1100, d); chk("R4 old base", d, 0);
  endtask

  task automatic t_resets;
    logic [31:0] d;
    bus_rd(B + 16'h00, d); chk("R5 00h", d, 0);
    bus_rd(B + 16'h0C, d); chk("R5 0Ch", d, 0);
    bus_rd(B + 16'h18, d); chk("R5 18h", d, 32'hE104_0005);
    bus_rd(B + 16'h34, d); chk("R5 34h", d, 32'h1);
    bus_rd(B + 16'h38, d); chk("R5 38h", d, 0);
  endtask

  task automatic t_lanes;
    logic [31:0] d;
    bus_wr(B + 16'h30, 4'hF, 32'hAABB_CCDD);
    bus_wr(B + 16'h30, 4'b0010, 32'h0000_1100);
    bus_rd(B + 16'h30, d); chk("R6 lane1 only", d, 32'hAABB_11DD);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    bus_wr(B + 16'h20, 4'hF, 32'hDEAD_BEEF);
    bus_rd(B + 16'h20, d); chk("R7 word 20h", d, 32'hDEAD_BEEF);
    bus_wr(B + 16'h04, 4'b1110, 32'h1234_5600);
    bus_rd(B + 16'h04, d); chk("R7 bytes 05h-07h", d, 32'h1234_5600);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    @(negedge clk); wd_evt = 8'h06;
    @(negedge clk); wd_evt = 0;
    bus_rd(B + 16'h04, d); chk("R8 set", {24'h0, d[7:0]}, 32'h06);
    bus_wr(B + 16'h04, 4'b0001, 32'h0000_0004);
    bus_rd(B + 16'h04, d); chk("R8 clear one", {24'h0, d[7:0]}, 32'h02);
    @(negedge clk); addr = B + 16'h04; be = 4'b0001; wdata = 32'hFF; wr = 1; wd_evt = 8'h02;
    @(negedge clk); wr = 0; be = 0; wd_evt = 0;
    bus_rd(B + 16'h04, d); chk("R8 set wins", {24'h0, d[7:0]}, 32'h02);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    bus_wr(B + 16'h08, 4'hF, 32'h0);
    bus_rd(B + 16'h08, d); chk("R9 timer", d, 32'hCAFE_F00D);
    tmr_value = 32'h0000_1234;
    bus_rd(B + 16'h08, d); chk("R9 timer live", d, 32'h0000_1234);
    bus_wr(B + 16'h10, 4'b0001, 32'hFF);
    bus_rd(B + 16'h10, d); chk("R9 strap byte / R5 12h", d, 32'h002F_000B);
    bus_wr(B + 16'h3C, 4'hF, 32'h0);
    bus_rd(B + 16'h3C, d); chk("R9 id/rev/base", d, {B, 8'h02, 8'hC4});
  endtask

  task automatic t_strap_rw;
    logic [31:0] d;
    bus_rd(B + 16'h1C, d); chk("R10 captured", {16'h0, d[31:16]}, 32'h1234);
    bus_wr(B + 16'h1C, 4'b1100, 32'hABCD_0000);
    bus_rd(B + 16'h1C, d); chk("R10 written", {16'h0, d[31:16]}, 32'hABCD);
  endtask

  task automatic t_idle;
    @(negedge clk); addr = B + 16'h18; rd = 0; #1;
    chk("R11 idle zero", rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_dark; t_boot; t_relock; t_decode; t_resets;
    t_lanes; t_reserved; t_w1c; t_readonly; t_strap_rw; t_idle;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule